// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a 32-bit load/store processor. On every clock edge that is not stalled, it computes the address of the next instruction from the current instruction word and loads that address into the PC. Sequential fetch adds four. A conditional branch adds a word offset to the address of the following instruction. An absolute jump keeps the top four PC bits and splices in a 26-bit word index. A register-indirect jump loads a register value supplied by the datapath.

The datapath supplies the register-equality result and the source register value. For a jump-and-link, the block presents PC+4 together with a one-cycle strobe so that the register file can write the return address into register 31.

Top module: `npc_unit`

## Requirements
- R1: After reset the PC output is 0x00400000 and the link strobe is low.
- R2: When the instruction is not a taken branch and not a jump, the next PC equals PC + 4. This covers R-format words with funct other than 8, all other I-format opcodes, and a branch whose condition fails.
- R3: Opcode 4 (instr[31:26]) is a branch when equal. When `regs_equal` is 1, the next PC is (PC + 4) + (instr[15:0] sign-extended, shifted left by 2). When `regs_equal` is 0, R2 applies.
- R4: Opcode 5 is a branch when not equal. It is taken when `regs_equal` is 0, with the same target formula as R3.
- R5: Negative branch offsets wrap in 32-bit arithmetic, so a branch can move the PC backward.
- R6: Opcodes 2 and 3 set the next PC to {PC[31:28], instr[25:0], 2'b00}.
- R7: Opcode 0 with funct 8 (instr[5:0]) loads the next PC from `rs_value`.
- R8: While opcode 3 is presented and `stall` is low, `link_we` is 1 in that cycle and `link_addr` equals PC + 4. For every other opcode, `link_we` is 0.
- R9: While `stall` is 1, the PC keeps its value and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction at the current PC |
| regs_equal | input | 1 | 1 when the two register operands are equal |
| rs_value | input | 32 | Source register value for a register jump |
| stall | input | 1 | Holds the PC and suppresses the link write |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | PC + 4, the return address |
| link_we | output | 1 | Strobe to write `link_addr` into register 31 |

## Verification
The hardest case to reach is a backward branch whose target wraps below address zero, or a jump whose upper PC bits are not those of the reset value. Reaching either requires first moving the PC into an unusual region. The bench uses register jumps with random `rs_value` to place the PC anywhere, including near zero and near the top of memory. It then applies random branches with negative offsets and random absolute jumps from there. Stalls are mixed in so that the hold behaviour is also seen in the middle of a taken branch and a jump-and-link.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int unsigned       XLEN     = 32,
  parameter logic [XLEN-1:0]   RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic            regs_equal,
  input  logic [XLEN-1:0] rs_value,
  input  logic            stall,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] link_addr,
  output logic            link_we
);
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_JLINK = 6'd3;
  localparam logic [5:0] OP_BREQ  = 6'd4;
  localparam logic [5:0] OP_BRNE  = 6'd5;
  localparam logic [5:0] FN_JREG  = 6'd8;

  logic [5:0]      opcode, funct;
  logic [XLEN-1:0] seq_pc, br_off, br_pc, jmp_pc, pc_next;
  logic            br_taken, is_jump, is_jreg;

  assign opcode   = instr[31:26];
  assign funct    = instr[5:0];
  assign seq_pc   = pc + XLEN'(4);
  assign br_off   = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign br_pc    = seq_pc + br_off;
  assign jmp_pc   = {pc[XLEN-1:28], instr[25:0], 2'b00};
  assign br_taken = (opcode == OP_BREQ && regs_equal) || (opcode == OP_BRNE && !regs_equal);
  assign is_jump  = (opcode == OP_JUMP) || (opcode == OP_JLINK);
  assign is_jreg  = (opcode == OP_RTYPE) && (funct == FN_JREG);

  always_comb begin
    pc_next = seq_pc;
    if (is_jreg)       pc_next = rs_value;
    else if (is_jump)  pc_next = jmp_pc;
    else if (br_taken) pc_next = br_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pc <= RESET_PC;
    else if (!stall) pc <= pc_next;
  end

  assign link_addr = seq_pc;
  assign link_we   = rst_n && !stall && (opcode == OP_JLINK);

  AST_RESET_VALUE: assert property (@(posedge clk) $past(!rst_n) |-> pc == RESET_PC) // R1
    else $error("reset pc");
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stall) && $past(rst_n) |-> $stable(pc)) // R9
    else $error("stall hold");
  AST_STALL_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n) stall |-> !link_we) // R9
    else $error("link during stall");
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && opcode != OP_JUMP && opcode != OP_JLINK && !is_jreg && !br_taken
    |=> pc == $past(pc) + XLEN'(4)) // R2
    else $error("sequential step");
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && is_jump |=> pc[XLEN-1:28] == $past(pc[XLEN-1:28]) && pc[1:0] == 2'b00) // R6
    else $error("jump region");
  AST_JREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && is_jreg |=> pc == $past(rs_value)) // R7
    else $error("register jump");
  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> opcode == OP_JLINK && link_addr == pc + XLEN'(4)) // R8
    else $error("link strobe");
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, regs_equal = 0, stall = 0;
  logic [31:0] instr = 0, rs_value = 0;
  logic [31:0] pc, link_addr;
  logic link_we;
  int checks = 0, errors = 0;
  logic [31:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit i_npc_unit (.clk, .rst_n, .instr, .regs_equal, .rs_value, .stall,
                       .pc, .link_addr, .link_we);

  function automatic logic [31:0] exp_next(logic [31:0] p, logic [31:0] ins,
                                           logic eq, logic [31:0] rsv);
    logic [5:0] op = ins[31:26];
    logic [31:0] off = {{14{ins[15]}}, ins[15:0], 2'b00};
    if (op == 0 && ins[5:0] == 8) return rsv;
    if (op == 2 || op == 3) return {p[31:28], ins[25:0], 2'b00};
    if ((op == 4 && eq) || (op == 5 && !eq)) return p + 4 + off;
    return p + 4;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one instruction for one cycle; inputs driven at negedge, results checked at next negedge
  task automatic step(string req, logic [31:0] ins, logic eq, logic [31:0] rsv, logic stl);
    logic [31:0] e;
    instr = ins; regs_equal = eq; rs_value = rsv; stall = stl;
    #1;
    check({req, " link_addr"}, link_addr, model_pc + 4);
    check({req, " link_we"}, {31'b0, link_we}, {31'b0, (!stl && ins[31:26] == 3)});
    e = stl ? model_pc : exp_next(model_pc, ins, eq, rsv);
    @(negedge clk);
    check({req, " pc"}, pc, e);
    model_pc = e;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 pc", pc, 32'h0040_0000);
    check("R1 link_we", {31'b0, link_we}, 0);
    model_pc = 32'h0040_0000;
    @(negedge clk);
    model_pc = 32'h0040_0000;
    // the reset-release cycle advanced pc sequentially (instr=0 is R-format, funct 0)
    model_pc = pc; check("R2 first step", pc, 32'h0040_0004);
    step("R2 alu op", 32'h0109_4020, 0, 0, 0);
    step("R2 addi", 32'h22D5_FFCE, 1, 0, 0);
    step("R3 beq taken", {6'd4, 10'd0, 16'd3}, 1, 0, 0);
    step("R3 beq not taken", {6'd4, 10'd0, 16'd3}, 0, 0, 0);
    step("R4 bne taken", {6'd5, 10'd0, 16'd7}, 0, 0, 0);
    step("R4 bne not taken", {6'd5, 10'd0, 16'd7}, 1, 0, 0);
    step("R5 backward", {6'd4, 10'd0, 16'hFFFC}, 1, 0, 0);
    step("R7 jr low", {6'd0, 20'd0, 6'd8}, 0, 32'h0000_0008, 0);
    step("R5 wrap below zero", {6'd5, 10'd0, 16'hFFF0}, 0, 0, 0);
    step("R6 j region", {6'd2, 26'h0100001}, 0, 0, 0);
    step("R7 jr high", {6'd0, 20'd0, 6'd8}, 0, 32'hA000_0010, 0);
    step("R6 j upper bits", {6'd2, 26'h3FFFFFF}, 0, 0, 0);
    step("R8 jal", {6'd3, 26'h0000040}, 0, 0, 0);
    step("R9 stall jal", {6'd3, 26'h0000080}, 0, 0, 1);
    step("R9 stall beq", {6'd4, 10'd0, 16'd5}, 1, 0, 1);
    step("R9 stall jr", {6'd0, 20'd0, 6'd8}, 0, 32'h1234_5678, 1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins = $urandom;
      int sel = $urandom_range(0, 7);
      case (sel)
        0: ins[31:26] = 6'd0;
        1: begin ins[31:26] = 6'd0; ins[5:0] = 6'd8; end
        2: ins[31:26] = 6'd2;
        3: ins[31:26] = 6'd3;
        4: ins[31:26] = 6'd4;
        5: ins[31:26] = 6'd5;
        default: ;
      endcase
      step("R2-mix random", ins, 1'($urandom), {$urandom} & 32'hFFFF_FFFC,
           ($urandom_range(0, 5) == 0));
    end
    rst_n = 0;
    @(negedge clk);
    check("R1 reset again", pc, 32'h0040_0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule